// File: doc/BRIEF.md
# Grouped Switch Debouncer

This block cleans up a group of slow, bouncing inputs such as mechanical switches or push buttons. The raw word passes through two registers clocked by the system clock. One shared stability counter watches the whole group. A change on any bit restarts the counter. The registered output word takes the new value only after every bit has held still for the full settling period.

Whenever the output word actually takes a different value, a one-cycle strobe goes high. Downstream logic uses it to act on the new word exactly once. Grouping several inputs behind one counter saves area. In exchange, a noisy bit delays the update of every other bit in the same group, so inputs should be grouped with that in mind.

The bus width (`WIDTH`) and the settling period in clock cycles (`SETTLE_CYCLES`, at least 1) are parameters. Everything runs on the single system clock, and reset is synchronous and active low.

Top module: `switch_group_debounce`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, both input stages, the counter, `data_o` and `strobe_o` are cleared to zero. After release, `data_o` reads all zeros and `strobe_o` reads 0 until an input word has settled.
- R2: The input word passes through exactly two register stages. If a new word is first sampled at edge c+1 and is then held, `data_o` shows it and `strobe_o` is high after edge c+`SETTLE_CYCLES`+3.
- R3: A difference between the two input stages on any bit clears the shared counter at the next edge. The change detection is the OR over all bits of the stage-to-stage XOR.
- R4: With no difference between the stages, the counter advances by one per edge until it reaches `SETTLE_CYCLES`. It then holds that value and never exceeds it.
- R5: `data_o` loads the second-stage word only on an edge where the counter already equals `SETTLE_CYCLES`. A word held for `SETTLE_CYCLES` sampled cycles or fewer never reaches the output. A word held for `SETTLE_CYCLES`+1 sampled cycles does.
- R6: `data_o` changes only on an edge that also sets `strobe_o`, apart from reset.
- R7: `strobe_o` is high for exactly one cycle, in the same cycle the new `data_o` first appears, and only when the loaded word differs from the previous output. Settling back to the word already on the output produces no strobe.
- R8: The counter is shared by the whole word. Bits that settled long ago are held back while any other bit keeps toggling at intervals shorter than the settling period. The whole word is then delivered with a single strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; every register uses its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| data_i | input | WIDTH | Raw, possibly bouncing switch levels |
| data_o | output | WIDTH | Registered, debounced word |
| strobe_o | output | 1 | One-cycle pulse marking a change of `data_o` |

## Verification
The only timed result is the update of `data_o` together with `strobe_o`. It falls on edge c+`SETTLE_CYCLES`+3, where c is the last edge before the driver changed `data_i`. The driver records c for each word it holds longer than the settling period and queues the word with that due cycle. The monitor samples on the falling clock edge, half a period after the load edge. At each strobe it compares the word and the current cycle number against the head of the queue. On every other cycle it requires `data_o` to keep its previous value, so a burst that ends too early, or a strobe that was not queued, shows up in the cycle where it occurs.

// File: rtl/sgd_pkg.sv
// Package: shared constants and helpers for the grouped switch debouncer.
// Assumes: callers pass a settling limit of at least 1.
package sgd_pkg;

    // Number of register stages the raw word crosses before change detection.
    localparam int unsigned SYNC_DEPTH = 2;

    // Width needed for a counter that must be able to hold the value 'limit'.
    function automatic int unsigned count_width(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/sgd_input_sync.sv
// Module: sgd_input_sync
// Registers the raw switch word twice on the system clock and flags any
// bit whose two stage values disagree.
// Assumes: the raw inputs change slowly compared with the clock.
module sgd_input_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] held_o,
    output logic             moved_o
);

    logic [WIDTH-1:0] first_q;
    logic [WIDTH-1:0] second_q;

    // Purpose: two-stage capture of the raw word, cleared by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            first_q  <= raw_i;
            second_q <= first_q;
        end
    end

    // Purpose: any lane differing between stages means the word is in motion.
    always_comb begin
        moved_o = |(first_q ^ second_q);
    end

    assign held_o = second_q;

endmodule

// File: rtl/sgd_settle_timer.sv
// Module: sgd_settle_timer
// One counter shared by the whole group. It is cleared by a restart request,
// otherwise it counts up and parks at the limit.
// Assumes: LIMIT >= 1.
module sgd_settle_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CNT_W = sgd_pkg::count_width(LIMIT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic             settled_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] count_q;

    // Purpose: restart on motion, else advance until the limit and hold there.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (restart_i) begin
            count_q <= '0;
        end else if (count_q != LIMIT_V) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Purpose: the word has been still for the full period.
    always_comb begin
        settled_o = (count_q == LIMIT_V);
    end

    assign count_o = count_q;

endmodule

// File: rtl/sgd_output_stage.sv
// Module: sgd_output_stage
// Output register loaded from the stable word when the timer has settled,
// plus a registered strobe that marks a real change of the output.
// Assumes: held_i is already registered and settled_i is glitch free.
module sgd_output_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             settled_i,
    input  logic [WIDTH-1:0] held_i,
    output logic [WIDTH-1:0] word_o,
    output logic             strobe_o
);

    logic [WIDTH-1:0] word_q;
    logic             strobe_q;
    logic             differs;

    // Purpose: detect whether the stable word is new with respect to the output.
    always_comb begin
        differs = |(held_i ^ word_q);
    end

    // Purpose: load the output word only while settled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q <= '0;
        end else if (settled_i) begin
            word_q <= held_i;
        end
    end

    // Purpose: pulse once, alongside the load that changes the output.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= settled_i & differs;
        end
    end

    assign word_o   = word_q;
    assign strobe_o = strobe_q;

endmodule

// File: rtl/switch_group_debounce.sv
// Module: switch_group_debounce (top)
// Debounces a group of switch inputs with one shared settling counter and
// flags every update of the output word with a one-cycle strobe.
// Assumes: a single free-running system clock, SETTLE_CYCLES >= 1.
module switch_group_debounce #(
    parameter int unsigned WIDTH         = 8,
    parameter int unsigned SETTLE_CYCLES = 100000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o,
    output logic             strobe_o
);

    localparam int unsigned CNT_W = sgd_pkg::count_width(SETTLE_CYCLES);

    logic [WIDTH-1:0] held_w;
    logic             moved_w;
    logic             settled_w;
    logic [CNT_W-1:0] count_w;

    // Purpose: capture the raw word and detect motion.
    sgd_input_sync #(
        .WIDTH (WIDTH)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (data_i),
        .held_o  (held_w),
        .moved_o (moved_w)
    );

    // Purpose: time how long the whole group has been still.
    sgd_settle_timer #(
        .LIMIT (SETTLE_CYCLES)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (moved_w),
        .settled_o (settled_w),
        .count_o   (count_w)
    );

    // Purpose: update the debounced word and raise the strobe.
    sgd_output_stage #(
        .WIDTH (WIDTH)
    ) out_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .settled_i (settled_w),
        .held_i    (held_w),
        .word_o    (data_o),
        .strobe_o  (strobe_o)
    );

endmodule

// File: rtl/sgd_checker.sv
// Module: sgd_checker
// Temporal checks on the debouncer, attached to the top with bind.
// Assumes: count_i is the shared settling counter of the top.
module sgd_checker #(
    parameter int unsigned WIDTH         = 8,
    parameter int unsigned SETTLE_CYCLES = 16,
    localparam int unsigned CNT_W = sgd_pkg::count_width(SETTLE_CYCLES)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] data_o,
    input logic             strobe_o,
    input logic [CNT_W-1:0] count_i
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(SETTLE_CYCLES);

    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_i <= LIMIT_V);

    assert_change_restarts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2) && ($past(data_i) != $past(data_i, 2)))
        |=> (count_i == '0));

    assert_load_needs_settle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && strobe_o) |-> ($past(count_i) == LIMIT_V));

    assert_quiet_output_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !strobe_o) |-> $stable(data_o));

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    assert_strobe_marks_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && strobe_o) |-> (data_o != $past(data_o)));

endmodule

bind switch_group_debounce sgd_checker #(
    .WIDTH         (WIDTH),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .data_o   (data_o),
    .strobe_o (strobe_o),
    .count_i  (count_w)
);

// File: tb/switch_group_debounce_tb_top.sv
// Scoreboard bench: the driver queues each word it holds long enough to
// settle, and the monitor pops and compares at every strobe.
module switch_group_debounce_tb_top;

    localparam int unsigned W    = 8;
    localparam int unsigned LIM  = 12;
    localparam int          WDOG = 20000;

    typedef struct {
        logic [W-1:0] word;
        int           due;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         strb;

    int           cyc = 0;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;
    exp_t         sb_q[$];
    logic [W-1:0] exp_last = '0;
    logic [W-1:0] prev_out = '0;

    always #4 clk = ~clk;

    switch_group_debounce #(
        .WIDTH         (W),
        .SETTLE_CYCLES (LIM)
    ) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .data_i   (din),
        .data_o   (dout),
        .strobe_o (strb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Driver: present a word for h cycles; queue it if it must settle.
    task automatic drive(input logic [W-1:0] v, input int h);
        exp_t e;
        din = v;
        if (h > int'(LIM) && v != exp_last) begin
            e.word = v;
            e.due  = cyc + int'(LIM) + 3;   // R2: two stages, count, load
            sb_q.push_back(e);
            exp_last = v;
        end
        repeat (h) @(negedge clk);
    endtask

    task automatic do_reset(input int len);
        din   = '0;
        rst_n = 1'b0;
        repeat (len) @(negedge clk);
        check(dout == '0, "R1", int'(dout), 0);
        check(strb == 1'b0, "R1", int'(strb), 0);
        rst_n    = 1'b1;
        exp_last = '0;
        @(negedge clk);
        check(dout == '0, "R1", int'(dout), 0);
    endtask

    // Monitor: compare each strobe with the queue head, otherwise demand a quiet output.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (strb) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", int'(dout), int'(prev_out));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(dout == e.word, "R2", int'(dout), int'(e.word));
                    check(cyc == e.due, "R2", cyc, e.due);
                end
            end else begin
                check(dout == prev_out, "R6", int'(dout), int'(prev_out));
            end
        end
        prev_out <= dout;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc == WDOG && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(dout == '0 && strb == 1'b0, "R1", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: a clean change, delivered after the full latency.
        drive(8'hA5, LIM + 6);

        // R3: bounce burst with short gaps, only the final word is delivered.
        drive(8'h5A, 3);
        drive(8'hA5, 2);
        drive(8'h5A, 5);
        drive(8'hFF, 1);
        drive(8'h3C, LIM + 6);

        // R5: hold of exactly LIM is dropped, LIM+1 is delivered.
        drive(8'h0F, LIM);
        drive(8'hF0, LIM + 1);
        drive(8'h0F, LIM + 8);

        // R7: a brief excursion settling back on the current output gives no strobe.
        drive(8'h00, 4);
        drive(8'h0F, LIM + 8);

        // R8: bit 0 keeps toggling, the settled upper bits wait with it.
        drive(8'hC1, LIM - 1);
        drive(8'hC0, LIM - 1);
        drive(8'hC1, LIM - 1);
        drive(8'hC0, LIM + 6);

        // R1: reset in mid run clears the output.
        drive(8'hFF, LIM + 6);
        check(dout == 8'hFF, "R6", int'(dout), 8'hFF);
        do_reset(3);
        drive(8'h81, LIM + 6);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2", sb_q.size(), 0);
        check(dout == 8'h81, "R5", int'(dout), 8'h81);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule